// File: doc/BRIEF.md
# Pipeline Hazard Detection and Forwarding Unit

This block holds the dependence-handling control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It compares the source register numbers of the instructions in decode and execute with the destination numbers held in the later pipeline registers. From that comparison it steers the two ALU operand multiplexers and decides whether the front of the pipeline must hold for a cycle.

Forwarding covers the ordinary read-after-write cases. A result still sitting in the EX/MEM register, or a result already in the MEM/WB register, is routed straight to the ALU inputs instead of the register file read value. One case cannot be covered this way: a load whose loaded value is wanted by the very next instruction. For that case the unit freezes the program counter and the IF/ID register for one cycle and clears ID/EX, so a bubble moves forward. On the next cycle the loaded value is picked up from MEM/WB.

The unit is purely combinational. It sits beside the pipeline registers and its outputs are consumed in the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: An operand select is 2'b10 (take the EX/MEM result) when EX/MEM has its write flag set, a nonzero destination, and that destination equals the execute-stage source of that operand.
- R2: An operand select is 2'b01 (take the MEM/WB result) when MEM/WB has its write flag set, a nonzero destination equal to the execute-stage source, and R1 does not apply.
- R3: When EX/MEM and MEM/WB both qualify for the same operand, the select is 2'b10: the newer producer wins.
- R4: A producer whose write flag is clear, or whose destination is register 0, never causes forwarding. The select is then 2'b00 (register file).
- R5: A load-use hazard stalls: ID/EX holds a load with its write flag set and a nonzero destination equal to either decode-stage source. The unit then drives pc_we=0, ifid_we=0 and idex_clr=1.
- R6: Without a load-use hazard the outputs are pc_we=1, ifid_we=1, idex_clr=0. In every cycle pc_we equals ifid_we and idex_clr is their inverse.
- R7: A non-load instruction in ID/EX whose destination matches a decode-stage source causes no stall.
- R8: In a running pipeline, a load followed directly by a consumer of its result stalls for exactly one cycle. When the consumer then reaches execute, its operand select is 2'b01.
- R9: Only read-after-write matters. Decode sources matching the EX/MEM or MEM/WB destinations never stall. An execute-stage instruction whose own destination equals its source gets no forwarding from that match (write-before-read in the register file covers writeback against decode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_a | input | REG_AW | First source register of the instruction in decode |
| id_rs_b | input | REG_AW | Second source register of the instruction in decode |
| ex_rs_a | input | REG_AW | First source register held in ID/EX |
| ex_rs_b | input | REG_AW | Second source register held in ID/EX |
| ex_rd | input | REG_AW | Destination register held in ID/EX |
| ex_wen | input | 1 | Register-write flag held in ID/EX |
| ex_is_load | input | 1 | Load flag held in ID/EX |
| mem_rd | input | REG_AW | Destination register held in EX/MEM |
| mem_wen | input | 1 | Register-write flag held in EX/MEM |
| wb_rd | input | REG_AW | Destination register held in MEM/WB |
| wb_wen | input | 1 | Register-write flag held in MEM/WB |
| sel_a | output | 2 | First ALU operand source: 00 file, 10 EX/MEM, 01 MEM/WB |
| sel_b | output | 2 | Second ALU operand source, same coding |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | IF/ID register write enable |
| idex_clr | output | 1 | Clear ID/EX to insert a bubble |

## Verification
The bench builds the unit with REG_AW=3, so register numbers come from only eight values. Random identifiers then collide often, and register 0 comes up often enough to exercise the zero-register and priority cases. A small instruction-level harness in the bench runs a load followed by dependent arithmetic through four stage models. This brings the one-cycle stall and the later MEM/WB forward within reach in an actual instruction sequence, not only as isolated input vectors.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/byp_pick.sv
module byp_pick
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output opnd_src_e         sel
);
  logic hit_mem, hit_wb;

  assign hit_mem = mem_wen && (mem_rd != '0) && (mem_rd == src);
  assign hit_wb  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);

  always_comb begin
    if (hit_mem)     sel = SRC_MEM;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_REGFILE;
  end

  // R4: with no writing producer nothing is forwarded
  always_comb begin
    if (!mem_wen && !wb_wen)
      a_r4_no_writer: assert (sel == SRC_REGFILE);
  end
endmodule

// File: rtl/ld_use_chk.sv
module ld_use_chk #(
  parameter int REG_AW = 5,
  parameter int N_SRC  = 2
) (
  input  logic [N_SRC-1:0][REG_AW-1:0] srcs,
  input  logic [REG_AW-1:0]            ld_rd,
  input  logic                         ld_wen,
  input  logic                         ld_flag,
  output logic                         stall
);
  logic [N_SRC-1:0] hit;
  logic             live_load;

  assign live_load = ld_flag && ld_wen && (ld_rd != '0);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = live_load && (srcs[g] == ld_rd);
  end

  assign stall = |hit;
endmodule

// File: rtl/stall_gate.sv
module stall_gate (
  input  logic stall,
  output logic pc_we,
  output logic ifid_we,
  output logic idex_clr
);
  assign pc_we    = !stall;
  assign ifid_we  = !stall;
  assign idex_clr = stall;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs_a,
  input  logic [REG_AW-1:0] id_rs_b,
  input  logic [REG_AW-1:0] ex_rs_a,
  input  logic [REG_AW-1:0] ex_rs_b,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_clr
);
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][REG_AW-1:0] ex_srcs;
  logic [N_OPND-1:0][REG_AW-1:0] id_srcs;
  opnd_src_e                     sel_arr [N_OPND];
  logic                          lu_stall;

  assign ex_srcs = {ex_rs_b, ex_rs_a};
  assign id_srcs = {id_rs_b, id_rs_a};

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    byp_pick #(.REG_AW(REG_AW)) u_pick (
      .src     (ex_srcs[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (sel_arr[g])
    );
  end

  assign sel_a = sel_arr[0];
  assign sel_b = sel_arr[1];

  ld_use_chk #(.REG_AW(REG_AW), .N_SRC(N_OPND)) u_lu (
    .srcs    (id_srcs),
    .ld_rd   (ex_rd),
    .ld_wen  (ex_wen),
    .ld_flag (ex_is_load),
    .stall   (lu_stall)
  );

  stall_gate u_gate (
    .stall    (lu_stall),
    .pc_we    (pc_we),
    .ifid_we  (ifid_we),
    .idex_clr (idex_clr)
  );

  always_comb begin
    // R6: front-end enables agree and are opposite to the bubble clear
    a_r6_enables_agree: assert ((pc_we == ifid_we) && (idex_clr == !pc_we));
    // R5 / R7: a bubble is only ever inserted behind a load
    if (idex_clr)
      a_r5_bubble_needs_load: assert (ex_is_load && ex_wen);
    // R3: a qualifying EX/MEM producer always wins
    if (mem_wen && (mem_rd != '0) && (mem_rd == ex_rs_a))
      a_r3_newest_wins: assert (sel_a == 2'b10);
    // R4: register 0 is never forwarded
    if (ex_rs_b == '0)
      a_r4_zero_reg: assert (sel_b == 2'b00);
  end
endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  localparam int BAW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [BAW-1:0] id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd;
  logic ex_wen, ex_is_load, mem_wen, wb_wen;
  logic [1:0] sel_a, sel_b;
  logic pc_we, ifid_we, idex_clr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  hazard_ctrl #(.REG_AW(BAW)) i_hazard_ctrl (
    .id_rs_a(id_rs_a), .id_rs_b(id_rs_b), .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .sel_a(sel_a), .sel_b(sel_b), .pc_we(pc_we), .ifid_we(ifid_we), .idex_clr(idex_clr)
  );

  typedef struct packed {
    logic           v;
    logic [BAW-1:0] rd;
    logic [BAW-1:0] rs1;
    logic [BAW-1:0] rs2;
    logic           ld;
    logic           we;
  } ins_t;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: newest producer first, zero register and disabled writers skipped
  function automatic int ref_sel(int src, int mrd, int mw, int wrd, int ww);
    int r = 0;
    if (ww != 0 && wrd != 0 && wrd == src) r = 1;
    if (mw != 0 && mrd != 0 && mrd == src) r = 2;
    return r;
  endfunction

  function automatic int ref_stall(int a, int b, int rd, int we, int ld);
    if (ld == 0 || we == 0 || rd == 0) return 0;
    return (a == rd || b == rd) ? 1 : 0;
  endfunction

  task automatic compare_all(input string rs, input string rst);
    int es = ref_stall(id_rs_a, id_rs_b, ex_rd, ex_wen, ex_is_load);
    check(sel_a == 2'(ref_sel(ex_rs_a, mem_rd, mem_wen, wb_rd, wb_wen)), rs, sel_a,
          ref_sel(ex_rs_a, mem_rd, mem_wen, wb_rd, wb_wen));
    check(sel_b == 2'(ref_sel(ex_rs_b, mem_rd, mem_wen, wb_rd, wb_wen)), rs, sel_b,
          ref_sel(ex_rs_b, mem_rd, mem_wen, wb_rd, wb_wen));
    check(pc_we == !es && ifid_we == !es && idex_clr == es, rst,
          {pc_we, ifid_we, idex_clr}, {!es, !es, es});
  endtask

  task automatic setv(int ia, int ib, int xa, int xb, int xrd, int xw, int xl,
                      int mrd, int mw, int wrd, int ww);
    @(posedge clk);
    id_rs_a = BAW'(ia); id_rs_b = BAW'(ib); ex_rs_a = BAW'(xa); ex_rs_b = BAW'(xb);
    ex_rd = BAW'(xrd); ex_wen = xw[0]; ex_is_load = xl[0];
    mem_rd = BAW'(mrd); mem_wen = mw[0]; wb_rd = BAW'(wrd); wb_wen = ww[0];
    @(negedge clk);
  endtask

  ins_t prog [6];
  ins_t ifid, idex, exmem, memwb;

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int stalls;
    id_rs_a = '0; id_rs_b = '0; ex_rs_a = '0; ex_rs_b = '0; ex_rd = '0;
    ex_wen = 0; ex_is_load = 0; mem_rd = '0; mem_wen = 0; wb_rd = '0; wb_wen = 0;
    @(negedge clk);
    // idle state: nothing pending
    check(sel_a == 2'b00 && sel_b == 2'b00, "R4 idle selects", sel_a, 0);
    check(pc_we && ifid_we && !idex_clr, "R6 idle enables", {pc_we, ifid_we, idex_clr}, 6);

    setv(0,0, 3,1, 0,0,0, 3,1, 0,0);
    check(sel_a == 2'b10, "R1 EX/MEM forward", sel_a, 2);
    check(sel_b == 2'b00, "R1 unrelated operand", sel_b, 0);
    setv(0,0, 1,2, 0,0,0, 5,1, 2,1);
    check(sel_b == 2'b01, "R2 MEM/WB forward", sel_b, 1);
    setv(0,0, 4,4, 0,0,0, 4,1, 4,1);
    check(sel_a == 2'b10 && sel_b == 2'b10, "R3 priority", {sel_a, sel_b}, 10);
    setv(0,0, 0,0, 0,0,0, 0,1, 0,1);
    check(sel_a == 2'b00 && sel_b == 2'b00, "R4 register zero", {sel_a, sel_b}, 0);
    setv(0,0, 6,6, 0,0,0, 6,0, 6,0);
    check(sel_a == 2'b00 && sel_b == 2'b00, "R4 write flag clear", {sel_a, sel_b}, 0);
    setv(1,5, 0,0, 5,1,1, 0,0, 0,0);
    check(!pc_we && !ifid_we && idex_clr, "R5 load-use stall", {pc_we, ifid_we, idex_clr}, 1);
    setv(0,0, 0,0, 0,1,1, 0,0, 0,0);
    check(pc_we && !idex_clr, "R5 load to register zero", {pc_we, idex_clr}, 2);
    setv(5,2, 0,0, 5,1,0, 0,0, 0,0);
    check(pc_we && ifid_we && !idex_clr, "R7 ALU producer no stall", {pc_we, ifid_we, idex_clr}, 6);
    setv(3,7, 0,0, 1,1,1, 3,1, 7,1);
    check(pc_we && !idex_clr, "R9 later producers no stall", {pc_we, idex_clr}, 2);
    setv(0,0, 2,2, 2,1,0, 0,0, 0,0);
    check(sel_a == 2'b00 && sel_b == 2'b00, "R9 own destination", {sel_a, sel_b}, 0);

    // random vectors with a small register space
    for (int i = 0; i < 3000; i++) begin
      setv($urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,7),
           $urandom_range(0,7), $urandom_range(0,1), $urandom_range(0,1),
           $urandom_range(0,7), $urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,1));
      compare_all("R1 R2 R3 random select", "R5 R6 random stall");
    end

    // instruction harness: load x5; x6=x5+x2; x7=x6+x5; x1=x7+x6
    prog[0] = '{v:1, rd:5, rs1:1, rs2:0, ld:1, we:1};
    prog[1] = '{v:1, rd:6, rs1:5, rs2:2, ld:0, we:1};
    prog[2] = '{v:1, rd:7, rs1:6, rs2:5, ld:0, we:1};
    prog[3] = '{v:1, rd:1, rs1:7, rs2:6, ld:0, we:1};
    prog[4] = '0;
    prog[5] = '0;
    ifid = '0; idex = '0; exmem = '0; memwb = '0;
    stalls = 0;
    for (int pc = 0, cyc = 0; cyc < 12; cyc++) begin
      int es;
      @(posedge clk);
      id_rs_a = ifid.rs1; id_rs_b = ifid.rs2;
      ex_rs_a = idex.rs1; ex_rs_b = idex.rs2; ex_rd = idex.rd;
      ex_wen = idex.we; ex_is_load = idex.ld;
      mem_rd = exmem.rd; mem_wen = exmem.we; wb_rd = memwb.rd; wb_wen = memwb.we;
      @(negedge clk);
      compare_all("R8 harness select", "R8 harness stall");
      es = ref_stall(ifid.rs1, ifid.rs2, idex.rd, idex.we, idex.ld);
      stalls += es;
      if (idex.v && idex.rd == 6)
        check(sel_a == 2'b01, "R8 consumer takes MEM/WB", sel_a, 1);
      memwb = exmem;
      exmem = idex;
      if (es != 0) idex = '0;
      else begin
        idex = ifid;
        ifid = (pc < 6) ? prog[pc] : '0;
        pc++;
      end
    end
    check(stalls == 1, "R8 single stall cycle", stalls, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule